// File: doc/BRIEF.md
# Processor Halt-State Clock Controller

This block is the power-management sequencer that sits beside a processor core and takes it into and out of its halted condition. When the instruction pipeline requests a halt, the block raises a halt special bus cycle request. It waits for the bus to acknowledge that cycle and then for the write buffer to report empty. Only then does it gate the core clock. While halted, a free-running time-stamp counter keeps advancing, and the block keeps watching the wake, snoop-hold and flush inputs.

The block can leave the halted condition for a while to let the system snoop the caches or flush them. After a snoop it returns straight to the halted condition with no new bus cycle. After a flush it runs the halt special cycle again before gating the clock. A wake event returns the core to normal operation and reports the winning wake source as a one-hot code. The bus interface, the flush engine and the snoop engine are outside the block and appear only as handshake signals.

Top module: `halt_clk_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled high, the block is in the running state: `core_clk_en_o`=1, `spc_req_o`=0, `flush_start_o`=0, `snoop_o`=0, `wake_o`=0 and `tsc_o`=0.
- R2: When `halt_req_i` is sampled high in the running state, `spc_req_o` rises in the next cycle and stays high until `bus_rdy_i` is sampled high, then falls. Write-buffer-empty is only considered in cycles after the one where bus-ready was sampled. `core_clk_en_o` falls in the cycle after `wb_empty_i` is sampled high.
- R3: `tsc_o` increases by one every cycle outside reset, in every state including the halted one, and wraps from 2^TSC_W-1 to 0.
- R4: In the halted state, a sampled wake source returns the block to the running state. In the next cycle `core_clk_en_o` is 1 and `wake_o` carries a one-cycle one-hot code naming the source.
- R5: In the halted state, `intr_i` sampled while `int_en_i` is 0 is ignored: `core_clk_en_o` stays 0 and `wake_o` stays 0.
- R6: Wake code bits are bit0 reset pin, bit1 init, bit2 SMI, bit3 NMI, bit4 maskable interrupt. When several wake sources arrive together, only the lowest-numbered bit is reported. A wake in the halted state also beats a flush or snoop request arriving in the same cycle.
- R7: In the halted state, `ahold_i`, `boff_i` or `bus_hold_i` sampled high moves the block to the snoop state in the next cycle, with `snoop_o`=1 and `core_clk_en_o`=1. When `snoop_done_i` is sampled there, the next cycle is halted again, with `core_clk_en_o`=0 and no `spc_req_o`.
- R8: In the halted state, `flush_i` sampled high gives a one-cycle `flush_start_o` pulse and sets `core_clk_en_o`=1. When `flush_done_i` is sampled, `spc_req_o` rises in the next cycle and the R2 entry sequence runs again.
- R9: In the running state with no halt request, `flush_i` gives a one-cycle `flush_start_o` pulse and the block stays in the running state.
- R10: `spc_req_o` holds the low value it had at the end of the halt special cycle for as long as the block stays halted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req_i | input | 1 | Halt request from the pipeline |
| bus_rdy_i | input | 1 | Bus ready for the special cycle |
| wb_empty_i | input | 1 | Write buffer empty |
| rst_pin_i | input | 1 | Reset-pin wake source |
| init_i | input | 1 | Init wake source |
| smi_i | input | 1 | System-management interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| intr_i | input | 1 | Maskable interrupt |
| int_en_i | input | 1 | Interrupt-enable flag |
| ahold_i | input | 1 | Address hold (snoop) |
| boff_i | input | 1 | Backoff (snoop) |
| bus_hold_i | input | 1 | Bus hold (snoop) |
| snoop_done_i | input | 1 | Snoop complete |
| flush_i | input | 1 | Cache flush request |
| flush_done_i | input | 1 | Flush complete |
| spc_req_o | output | 1 | Halt special cycle request |
| core_clk_en_o | output | 1 | Core clock enable |
| tsc_o | output | TSC_W | Time-stamp counter |
| flush_start_o | output | 1 | Flush start pulse |
| snoop_o | output | 1 | In snoop service |
| wake_o | output | 5 | One-hot wake event code, one cycle |

## Verification
The hardest situations to reach are the excursions out of the halted state: a snoop must come back without a new special cycle, and a flush must come back through one. A further case is a wake that lands in the same cycle as a flush or snoop request. The stimulus always drives the full entry handshake first. It holds write-buffer-empty high before bus-ready arrives, to show that it is not counted too early. It then raises snoop holds, flush, or several wake sources together with flush and snoop, and follows each excursion to its return.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [2:0] {
    ST_RUN,
    ST_SPC,
    ST_WBE,
    ST_HALT,
    ST_SNOOP,
    ST_FLUSH
  } hstate_t;

  localparam int WAKE_N   = 5;
  localparam int WK_RST   = 0;
  localparam int WK_INIT  = 1;
  localparam int WK_SMI   = 2;
  localparam int WK_NMI   = 3;
  localparam int WK_INTR  = 4;
endpackage

// File: rtl/halt_wake_arb.sv
module halt_wake_arb #(
  parameter int N = 5
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] grant,
  output logic         any
);
  for (genvar i = 0; i < N; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant[i] = req[i];
    end else begin : g_rest
      assign grant[i] = req[i] & ~(|req[i-1:0]);
    end
  end
  assign any = |req;
endmodule

// File: rtl/halt_tsc.sv
module halt_tsc #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/halt_fsm.sv
module halt_fsm
  import halt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic              bus_rdy,
  input  logic              wb_empty,
  input  logic              wake_any,
  input  logic [WAKE_N-1:0] wake_grant,
  input  logic              snoop_req,
  input  logic              snoop_done,
  input  logic              flush_req,
  input  logic              flush_done,
  output logic              spc_req,
  output logic              clk_en,
  output logic              flush_start,
  output logic              snoop_act,
  output logic [WAKE_N-1:0] wake_code
);
  hstate_t st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st          <= ST_RUN;
      spc_req     <= 1'b0;
      clk_en      <= 1'b1;
      flush_start <= 1'b0;
      snoop_act   <= 1'b0;
      wake_code   <= '0;
    end else begin
      flush_start <= 1'b0;
      wake_code   <= '0;
      unique case (st)
        ST_RUN: begin
          if (halt_req) begin
            st      <= ST_SPC;
            spc_req <= 1'b1;
          end else if (flush_req) begin
            flush_start <= 1'b1;
          end
        end
        ST_SPC: begin
          if (bus_rdy) begin
            st      <= ST_WBE;
            spc_req <= 1'b0;
          end
        end
        ST_WBE: begin
          if (wb_empty) begin
            st     <= ST_HALT;
            clk_en <= 1'b0;
          end
        end
        ST_HALT: begin
          if (wake_any) begin
            st        <= ST_RUN;
            clk_en    <= 1'b1;
            wake_code <= wake_grant;
          end else if (flush_req) begin
            st          <= ST_FLUSH;
            clk_en      <= 1'b1;
            flush_start <= 1'b1;
          end else if (snoop_req) begin
            st        <= ST_SNOOP;
            clk_en    <= 1'b1;
            snoop_act <= 1'b1;
          end
        end
        ST_SNOOP: begin
          if (snoop_done) begin
            st        <= ST_HALT;
            clk_en    <= 1'b0;
            snoop_act <= 1'b0;
          end
        end
        ST_FLUSH: begin
          if (flush_done) begin
            st      <= ST_SPC;
            spc_req <= 1'b1;
          end
        end
        default: st <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/halt_clk_ctrl.sv
module halt_clk_ctrl
  import halt_pkg::*;
#(
  parameter int TSC_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req_i,
  input  logic              bus_rdy_i,
  input  logic              wb_empty_i,
  input  logic              rst_pin_i,
  input  logic              init_i,
  input  logic              smi_i,
  input  logic              nmi_i,
  input  logic              intr_i,
  input  logic              int_en_i,
  input  logic              ahold_i,
  input  logic              boff_i,
  input  logic              bus_hold_i,
  input  logic              snoop_done_i,
  input  logic              flush_i,
  input  logic              flush_done_i,
  output logic              spc_req_o,
  output logic              core_clk_en_o,
  output logic [TSC_W-1:0]  tsc_o,
  output logic              flush_start_o,
  output logic              snoop_o,
  output logic [WAKE_N-1:0] wake_o
);
  logic [WAKE_N-1:0] wake_req;
  logic [WAKE_N-1:0] wake_grant;
  logic              wake_any;
  logic              snoop_req;

  always_comb begin
    wake_req          = '0;
    wake_req[WK_RST]  = rst_pin_i;
    wake_req[WK_INIT] = init_i;
    wake_req[WK_SMI]  = smi_i;
    wake_req[WK_NMI]  = nmi_i;
    wake_req[WK_INTR] = intr_i & int_en_i;
  end

  assign snoop_req = ahold_i | boff_i | bus_hold_i;

  halt_wake_arb #(.N(WAKE_N)) u_arb (
    .req   (wake_req),
    .grant (wake_grant),
    .any   (wake_any)
  );

  halt_tsc #(.W(TSC_W)) u_tsc (
    .clk (clk),
    .rst (rst),
    .cnt (tsc_o)
  );

  halt_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .halt_req    (halt_req_i),
    .bus_rdy     (bus_rdy_i),
    .wb_empty    (wb_empty_i),
    .wake_any    (wake_any),
    .wake_grant  (wake_grant),
    .snoop_req   (snoop_req),
    .snoop_done  (snoop_done_i),
    .flush_req   (flush_i),
    .flush_done  (flush_done_i),
    .spc_req     (spc_req_o),
    .clk_en      (core_clk_en_o),
    .flush_start (flush_start_o),
    .snoop_act   (snoop_o),
    .wake_code   (wake_o)
  );
endmodule

// File: rtl/halt_clk_ctrl_chk.sv
module halt_clk_ctrl_chk #(
  parameter int TSC_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             wb_empty_i,
  input logic             int_en_i,
  input logic             snoop_done_i,
  input logic             spc_req_o,
  input logic             core_clk_en_o,
  input logic [TSC_W-1:0] tsc_o,
  input logic             flush_start_o,
  input logic             snoop_o,
  input logic [4:0]       wake_o
);
  AST_CLK_GATE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $fell(core_clk_en_o) |-> ($past(wb_empty_i) || $past(snoop_done_i))); // R2
  AST_TSC_STEP: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (tsc_o == $past(tsc_o) + 1'b1)); // R3
  AST_WAKE_CLK_ON: assert property (@(posedge clk) disable iff (rst)
    (wake_o != 5'd0) |-> core_clk_en_o); // R4
  AST_WAKE_PULSE: assert property (@(posedge clk) disable iff (rst)
    (wake_o != 5'd0) |=> (wake_o == 5'd0)); // R4
  AST_INTR_MASKED: assert property (@(posedge clk) disable iff (rst)
    wake_o[4] |-> $past(int_en_i)); // R5
  AST_WAKE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wake_o)); // R6
  AST_SNOOP_RETURN: assert property (@(posedge clk) disable iff (rst)
    $fell(snoop_o) |-> (!core_clk_en_o && !spc_req_o)); // R7
  AST_SNOOP_CLK_ON: assert property (@(posedge clk) disable iff (rst)
    snoop_o |-> core_clk_en_o); // R7
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (rst)
    flush_start_o |=> !flush_start_o); // R8
  AST_HALT_BUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !core_clk_en_o |-> !spc_req_o); // R10
endmodule

bind halt_clk_ctrl halt_clk_ctrl_chk #(.TSC_W(TSC_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .wb_empty_i    (wb_empty_i),
  .int_en_i      (int_en_i),
  .snoop_done_i  (snoop_done_i),
  .spc_req_o     (spc_req_o),
  .core_clk_en_o (core_clk_en_o),
  .tsc_o         (tsc_o),
  .flush_start_o (flush_start_o),
  .snoop_o       (snoop_o),
  .wake_o        (wake_o)
);

// File: tb/halt_clk_ctrl_tb_top.sv
`timescale 1ns/1ps
module halt_clk_ctrl_tb_top;
  localparam int TW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic halt_req = 0, bus_rdy = 0, wb_empty = 0;
  logic rst_pin = 0, init = 0, smi = 0, nmi = 0, intr = 0, int_en = 0;
  logic ahold = 0, boff = 0, bus_hold = 0, snoop_done = 0;
  logic flush = 0, flush_done = 0;
  logic spc_req, clk_en, flush_start, snoop;
  logic [TW-1:0] tsc;
  logic [4:0] wake;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  halt_clk_ctrl #(.TSC_W(TW)) dut_i (
    .clk(clk), .rst(rst), .halt_req_i(halt_req), .bus_rdy_i(bus_rdy),
    .wb_empty_i(wb_empty), .rst_pin_i(rst_pin), .init_i(init), .smi_i(smi),
    .nmi_i(nmi), .intr_i(intr), .int_en_i(int_en), .ahold_i(ahold),
    .boff_i(boff), .bus_hold_i(bus_hold), .snoop_done_i(snoop_done),
    .flush_i(flush), .flush_done_i(flush_done), .spc_req_o(spc_req),
    .core_clk_en_o(clk_en), .tsc_o(tsc), .flush_start_o(flush_start),
    .snoop_o(snoop), .wake_o(wake)
  );

  typedef struct {
    string    tag;
    bit       chk;
    logic     spc;
    logic     cen;
    logic     fs;
    logic     snp;
    logic [4:0] wk;
  } exp_t;

  exp_t sb_q[$];
  logic [TW-1:0] tsc_m = '0;
  bit done = 0;

  always @(posedge clk) tsc_m <= rst ? '0 : tsc_m + 1'b1;

  // monitor: pops one expected item per cycle
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        if (e.chk) begin
          checks++;
          if (spc_req !== e.spc || clk_en !== e.cen || flush_start !== e.fs ||
              snoop !== e.snp || wake !== e.wk) begin
            errors++;
            $display("FAIL %s: got spc=%b cen=%b fs=%b snp=%b wake=%b exp spc=%b cen=%b fs=%b snp=%b wake=%b",
                     e.tag, spc_req, clk_en, flush_start, snoop, wake,
                     e.spc, e.cen, e.fs, e.snp, e.wk);
          end
          checks++;
          if (tsc !== tsc_m) begin
            errors++;
            $display("FAIL R3 (%s): tsc got %0d exp %0d", e.tag, tsc, tsc_m);
          end
        end
      end
    end
  end

  // driver: push the expectation for the next cycle, then advance
  task automatic cyc(string tag, logic s, logic c, logic f, logic n, logic [4:0] w, bit chk = 1);
    exp_t e;
    e.tag = tag; e.chk = chk; e.spc = s; e.cen = c; e.fs = f; e.snp = n; e.wk = w;
    sb_q.push_back(e);
    @(negedge clk);
  endtask

  task automatic go_halt(string tag);
    halt_req = 1; cyc({tag, " R2 spc"}, 1, 1, 0, 0, 0); halt_req = 0;
    bus_rdy = 1;  cyc({tag, " R2 rdy"}, 0, 1, 0, 0, 0); bus_rdy = 0;
    wb_empty = 1; cyc({tag, " R2 halt"}, 0, 0, 0, 0, 0); wb_empty = 0;
  endtask

  initial begin
    #(200000 * 8);
    errors++; checks++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    @(negedge clk);
    cyc("R1 reset", 0, 1, 0, 0, 0);
    cyc("R1 reset", 0, 1, 0, 0, 0);
    rst = 0;
    cyc("R1 after reset", 0, 1, 0, 0, 0);

    // R2 entry, write-buffer-empty early is not counted
    halt_req = 1; wb_empty = 1;
    cyc("R2 spc rise", 1, 1, 0, 0, 0); halt_req = 0;
    cyc("R2 wbe before rdy", 1, 1, 0, 0, 0);
    bus_rdy = 1; wb_empty = 0;
    cyc("R2 rdy seen", 0, 1, 0, 0, 0); bus_rdy = 0;
    cyc("R2 wait wbe", 0, 1, 0, 0, 0);
    wb_empty = 1;
    cyc("R2 clock gated", 0, 0, 0, 0, 0); wb_empty = 0;
    for (int i = 0; i < 4; i++) cyc("R10 halted holds", 0, 0, 0, 0, 0);

    // R5 masked interrupt
    intr = 1; int_en = 0;
    cyc("R5 masked intr", 0, 0, 0, 0, 0);
    cyc("R5 still halted", 0, 0, 0, 0, 0);
    int_en = 1;
    cyc("R4 intr wake", 0, 1, 0, 0, 5'b10000); intr = 0; int_en = 0;
    cyc("R4 wake pulse ends", 0, 1, 0, 0, 0);

    // R6 priority
    go_halt("p1");
    nmi = 1; smi = 1; init = 1;
    cyc("R6 init wins", 0, 1, 0, 0, 5'b00010); nmi = 0; smi = 0; init = 0;
    go_halt("p2");
    nmi = 1; smi = 1; rst_pin = 1; intr = 1; int_en = 1;
    cyc("R6 reset pin wins", 0, 1, 0, 0, 5'b00001);
    nmi = 0; smi = 0; rst_pin = 0; intr = 0; int_en = 0;
    go_halt("p3");
    nmi = 1; smi = 1;
    cyc("R6 smi over nmi", 0, 1, 0, 0, 5'b00100); nmi = 0; smi = 0;
    go_halt("p4");
    nmi = 1; ahold = 1; flush = 1;
    cyc("R6 wake beats flush/snoop", 0, 1, 0, 0, 5'b01000);
    nmi = 0; ahold = 0; flush = 0;
    cyc("R6 running", 0, 1, 0, 0, 0);

    // R7 snoop excursions
    go_halt("s1");
    ahold = 1;
    cyc("R7 snoop enter ahold", 0, 1, 0, 1, 0); ahold = 0;
    cyc("R7 snoop wait", 0, 1, 0, 1, 0);
    snoop_done = 1;
    cyc("R7 snoop return", 0, 0, 0, 0, 0); snoop_done = 0;
    cyc("R7 R10 no new spc", 0, 0, 0, 0, 0);
    boff = 1;
    cyc("R7 snoop enter boff", 0, 1, 0, 1, 0); boff = 0; snoop_done = 1;
    cyc("R7 snoop return 2", 0, 0, 0, 0, 0); snoop_done = 0;
    bus_hold = 1;
    cyc("R7 snoop enter hold", 0, 1, 0, 1, 0); bus_hold = 0; snoop_done = 1;
    cyc("R7 snoop return 3", 0, 0, 0, 0, 0); snoop_done = 0;

    // R8 flush from halt
    flush = 1; ahold = 1;
    cyc("R8 flush start", 0, 1, 1, 0, 0); flush = 0; ahold = 0;
    cyc("R8 flush busy", 0, 1, 0, 0, 0);
    flush_done = 1;
    cyc("R8 spc again", 1, 1, 0, 0, 0); flush_done = 0;
    bus_rdy = 1;
    cyc("R8 rdy", 0, 1, 0, 0, 0); bus_rdy = 0; wb_empty = 1;
    cyc("R8 halted again", 0, 0, 0, 0, 0); wb_empty = 0;
    init = 1;
    cyc("R4 init wake", 0, 1, 0, 0, 5'b00010); init = 0;

    // R9 flush in running state
    flush = 1;
    cyc("R9 flush in run", 0, 1, 1, 0, 0); flush = 0;
    cyc("R9 still run", 0, 1, 0, 0, 0);

    // R3 wrap of the counter
    for (int i = 0; i < 300; i++) cyc("R3 wrap run", 0, 1, 0, 0, 0);

    // R1 reset from halted
    go_halt("r1");
    rst = 1;
    cyc("R1 reset from halt", 0, 1, 0, 0, 0); rst = 0;
    cyc("R1 after reset 2", 0, 1, 0, 0, 0);

    cyc("drain", 0, 1, 0, 0, 0, 0);
    cyc("drain", 0, 1, 0, 0, 0, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule